// File: doc/BRIEF.md
# Sidetone Filter and Mixer

This block takes a mono received audio stream, runs it through a 128-tap FIR filter, and adds the result back into a two-channel transmit stream. Each channel has its own gain. A user hears a filtered copy of their own voice in the earpiece. Each input beat carries one received sample and one transmit sample per channel. Each accepted beat yields exactly one output beat. Both sides use a valid/ready handshake.

The block is configured through a small write-only register port with three registers:

- **Address 0, control.** Bit 0 turns the mixed path on. Bit 1 opens a coefficient load window.
- **Address 1, coefficient data.** Bits 15:0 hold one signed tap. The taps are streamed through this register one at a time.
- **Address 2, gain.** Bits 15:0 hold the channel 0 gain and bits 31:16 hold the channel 1 gain. Both are signed Q1.15.

A status output reports when a full tap set has been captured. While the mixed path is off, transmit samples go through unchanged. The filter uses one multiply-accumulate per clock.

Top module: `sidetone_fir`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `coef_done` is 0, and all taps, history entries and gains are zero.
- R2: A control write with bit 1 set, when the load window was closed, rewinds the tap pointer to index 0 and clears `coef_done` on the next cycle.
- R3: `coef_done` rises in the cycle after the 128th accepted coefficient write of a session. It stays 0 before that, and it holds until the next session opens, including after the window closes.
- R4: A coefficient write has no effect on any stored tap in two cases: when the load window is closed, or when 128 taps have already been written in the current session.
- R5: When the path is on, the filtered value is the sum over k of tap[k]·hist[k], rounded (add 2^14, arithmetic shift right by 15) and saturated to 16 bits. hist[0] is the newest received sample. The history shifts on every accepted beat, whether the path is on or off.
- R6: Each channel adds the filtered value, scaled by its gain, to its transmit sample. The scaling is the product rounded by 15 bits and saturated to 16 bits. The sum is also saturated to 16 bits.
- R7: When the path is off at the time a beat is accepted, `out_valid` rises on the next cycle and both outputs equal the beat's transmit samples.
- R8: `in_ready` is low from acceptance until the output beat is taken. A pending output holds its value while `out_ready` is low.
- R9: When the path is on at acceptance, `out_valid` rises exactly 128 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 coefficient, 2 gain |
| cfg_wdata | input | 32 | Register write data |
| coef_done | output | 1 | Full tap set captured in this session |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_rx | input | 16 | Received sample to filter |
| in_tx0 | input | 16 | Transmit sample, channel 0 |
| in_tx1 | input | 16 | Transmit sample, channel 1 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink takes the output beat |
| out_tx0 | output | 16 | Mixed sample, channel 0 |
| out_tx1 | output | 16 | Mixed sample, channel 1 |

## Verification
The assertions assume that the gain register is not written while an output beat is pending, since the mixed output is formed from it combinationally. They also assume that taps are not reloaded while a beat is inside the filter. The stimulus writes registers only while `in_ready` is high, never in the same cycle as an accepted beat. It also keeps the gains fixed for the whole run of samples that follows. The reference model therefore computes each expected output from the taps, history and gains seen at acceptance time.

// File: rtl/sidetone_fir.sv
module sidetone_fir #(
  parameter int DW   = 16,
  parameter int TAPS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [2*DW-1:0]      cfg_wdata,
  output logic                 coef_done,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_rx,
  input  logic signed [DW-1:0] in_tx0,
  input  logic signed [DW-1:0] in_tx1,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_tx0,
  output logic signed [DW-1:0] out_tx1
);
  localparam int PW   = $clog2(TAPS);
  localparam int ACCW = 2*DW + PW + 1;
  localparam logic [PW:0]   NTAP = (PW+1)'(TAPS);
  localparam logic [PW:0]   LASTW = (PW+1)'(TAPS-1);
  localparam logic [PW-1:0] LAST = PW'(TAPS-1);
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (DW-2);
  localparam logic signed [ACCW-1:0] HI = (ACCW'(1) <<< (DW-1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] LO = ~HI;

  typedef enum logic [1:0] {S_IDLE, S_MAC, S_OUT} state_t;

  function automatic logic signed [ACCW-1:0] wide(input logic signed [2*DW-1:0] v);
    return $signed({{(ACCW-2*DW){v[2*DW-1]}}, v});
  endfunction

  function automatic logic signed [ACCW-1:0] wide1(input logic signed [DW-1:0] v);
    return $signed({{(ACCW-DW){v[DW-1]}}, v});
  endfunction

  function automatic logic signed [ACCW-1:0] qround(input logic signed [ACCW-1:0] v);
    return (v + HALF) >>> (DW-1);
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [ACCW-1:0] v);
    if (v > HI) return HI[DW-1:0];
    if (v < LO) return LO[DW-1:0];
    return v[DW-1:0];
  endfunction

  state_t state;
  logic wen_q, en_q, run_en, done_q;
  logic [PW:0] wr_ptr;
  logic [PW-1:0] tap;
  logic signed [DW-1:0] gain0, gain1, tx0_q, tx1_q, filt_q;
  logic signed [DW-1:0] coef [TAPS];
  logic signed [DW-1:0] hist [TAPS];
  logic signed [ACCW-1:0] acc, acc_nx;
  logic signed [2*DW-1:0] prod, scl0, scl1;
  logic signed [DW-1:0] side0, side1;
  logic ctl_wr, coef_wr, take;

  assign ctl_wr  = cfg_we && cfg_addr == 2'd0;
  assign coef_wr = cfg_we && cfg_addr == 2'd1 && wen_q && wr_ptr < NTAP;
  assign take    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      wr_ptr <= '0;
      gain0  <= '0;
      gain1  <= '0;
    end else begin
      if (ctl_wr) begin
        en_q  <= cfg_wdata[0];
        wen_q <= cfg_wdata[1];
        if (cfg_wdata[1] && !wen_q) begin
          wr_ptr <= '0;
          done_q <= 1'b0;
        end
      end
      if (coef_wr) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (wr_ptr == LASTW) done_q <= 1'b1;
      end
      if (cfg_we && cfg_addr == 2'd2) begin
        gain0 <= cfg_wdata[DW-1:0];
        gain1 <= cfg_wdata[2*DW-1:DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) coef[i] <= '0;
    end else if (coef_wr) begin
      coef[wr_ptr[PW-1:0]] <= cfg_wdata[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
    end else if (take) begin
      hist[0] <= in_rx;
      for (int i = 1; i < TAPS; i++) hist[i] <= hist[i-1];
    end
  end

  assign prod   = hist[tap] * coef[tap];
  assign acc_nx = acc + wide(prod);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      tap    <= '0;
      acc    <= '0;
      filt_q <= '0;
      tx0_q  <= '0;
      tx1_q  <= '0;
      run_en <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          tx0_q  <= in_tx0;
          tx1_q  <= in_tx1;
          run_en <= en_q;
          tap    <= '0;
          acc    <= '0;
          state  <= en_q ? S_MAC : S_OUT;
        end
        S_MAC: begin
          acc <= acc_nx;
          tap <= tap + 1'b1;
          if (tap == LAST) begin
            filt_q <= clip(qround(acc_nx));
            state  <= S_OUT;
          end
        end
        S_OUT: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign scl0  = filt_q * gain0;
  assign scl1  = filt_q * gain1;
  assign side0 = clip(qround(wide(scl0)));
  assign side1 = clip(qround(wide(scl1)));

  assign out_tx0   = run_en ? clip(wide1(tx0_q) + wide1(side0)) : tx0_q;
  assign out_tx1   = run_en ? clip(wide1(tx1_q) + wide1(side1)) : tx1_q;
  assign in_ready  = state == S_IDLE;
  assign out_valid = state == S_OUT;
  assign coef_done = done_q;
endmodule

// File: rtl/sidetone_fir_chk.sv
module sidetone_fir_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic [2*DW-1:0] cfg_wdata,
  input logic          coef_done,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_tx0,
  input logic [DW-1:0] out_tx1,
  input logic          wen_q,
  input logic          en_q
);
  logic open_wr;
  assign open_wr = cfg_we && cfg_addr == 2'd0 && cfg_wdata[1] && !wen_q;

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tx0) && $stable(out_tx1));

  p_open_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    open_wr |=> !coef_done);

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coef_done && !open_wr |=> coef_done);

  p_closed_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_done && !wen_q |=> !coef_done);

  p_bypass_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !en_q |=> out_valid);

  p_filter_not_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && en_q |=> !out_valid && !in_ready);
endmodule

bind sidetone_fir sidetone_fir_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .coef_done(coef_done), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_tx0(out_tx0), .out_tx1(out_tx1), .wen_q(wen_q), .en_q(en_q)
);

// File: tb/sidetone_fir_tb_top.sv
module sidetone_fir_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic coef_done, in_ready, out_valid;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [15:0] in_rx = '0, in_tx0 = '0, in_tx1 = '0;
  logic [15:0] out_tx0, out_tx1;

  sidetone_fir dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .coef_done(coef_done), .in_valid(in_valid),
    .in_ready(in_ready), .in_rx(in_rx), .in_tx0(in_tx0), .in_tx1(in_tx1),
    .out_valid(out_valid), .out_ready(out_ready), .out_tx0(out_tx0),
    .out_tx1(out_tx1)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit stall = 0, fin = 0;
  int seed = 7, seed2 = 99;

  int m_coef[128], m_hist[128];
  int m_ptr, m_phase, m_cnt, m_g0, m_g1, m_e0, m_e1;
  bit m_en, m_wen, m_done;
  longint m_acc, m_y;

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rq(longint v);
    return (v + 16384) >>> 15;
  endfunction

  function automatic int rnd16();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) begin m_coef[i] = 0; m_hist[i] = 0; end
      m_ptr = 0; m_phase = 0; m_cnt = 0; m_g0 = 0; m_g1 = 0;
      m_e0 = 0; m_e1 = 0; m_en = 0; m_wen = 0; m_done = 0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin
            if (cfg_wdata[1] && !m_wen) begin m_ptr = 0; m_done = 0; end
            m_en = cfg_wdata[0];
            m_wen = cfg_wdata[1];
          end
          2'd1: if (m_wen && m_ptr < 128) begin
            m_coef[m_ptr] = int'($signed(cfg_wdata[15:0]));
            m_ptr++;
            if (m_ptr == 128) m_done = 1;
          end
          2'd2: begin
            m_g0 = int'($signed(cfg_wdata[15:0]));
            m_g1 = int'($signed(cfg_wdata[31:16]));
          end
          default: ;
        endcase
      end
      case (m_phase)
        0: if (in_valid) begin
          for (int i = 127; i > 0; i--) m_hist[i] = m_hist[i-1];
          m_hist[0] = int'($signed(in_rx));
          if (m_en) begin
            m_acc = 0;
            for (int k = 0; k < 128; k++) m_acc += longint'(m_coef[k]) * m_hist[k];
            m_y = sat16(rq(m_acc));
            m_e0 = int'(sat16(longint'($signed(in_tx0)) + sat16(rq(m_y * m_g0))));
            m_e1 = int'(sat16(longint'($signed(in_tx1)) + sat16(rq(m_y * m_g1))));
            m_phase = 1; m_cnt = 128;
          end else begin
            m_e0 = int'($signed(in_tx0)); m_e1 = int'($signed(in_tx1));
            m_phase = 2;
          end
        end
        1: begin m_cnt--; if (m_cnt == 0) m_phase = 2; end
        2: if (out_ready) m_phase = 0;
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk("R8 in_ready", in_ready, m_phase == 0);
      chk("R9 out_valid", out_valid, m_phase == 2);
      if (out_valid && m_phase == 2) begin
        chk({cur_req, " ch0"}, $signed(out_tx0), m_e0);
        chk({cur_req, " ch1"}, $signed(out_tx1), m_e1);
      end
      chk("R3 coef_done", coef_done, m_done);
    end
  end

  always @(negedge clk) begin
    seed2 = seed2 * 69069 + 1;
    out_ready = stall ? seed2[16] : 1'b1;
  end

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    while (!in_ready) @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input int rx, input int t0, input int t1);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_rx = rx[15:0]; in_tx0 = t0[15:0]; in_tx1 = t1[15:0];
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 coef_done", coef_done, 0);

    cur_req = "R7";
    for (int i = 0; i < 6; i++) send(rnd16(), rnd16(), rnd16());
    send(100, 32767, -32768);
    cfg(2'd0, 32'h0);

    cur_req = "R4";
    cfg(2'd1, 32'd12345);
    chk("R4 closed write", coef_done, 0);

    cfg(2'd0, 32'h2);
    chk("R2 open clears", coef_done, 0);
    for (int i = 0; i < 127; i++) cfg(2'd1, {16'h0, 16'(rnd16() / 8)});
    chk("R3 before last", coef_done, 0);
    cfg(2'd1, 32'h0000_4000);
    chk("R3 after last", coef_done, 1);
    for (int i = 0; i < 3; i++) cfg(2'd1, 32'h0000_7fff);
    chk("R4 overflow writes", coef_done, 1);
    cfg(2'd0, 32'h0);
    chk("R3 after close", coef_done, 1);
    cfg(2'd2, 32'hc000_7fff);

    cur_req = "R5";
    cfg(2'd0, 32'h1);
    for (int i = 0; i < 10; i++) send(rnd16(), rnd16() / 2, rnd16() / 2);

    cur_req = "R9";
    while (!in_ready) @(negedge clk);
    send(1234, 10, -10);
    begin
      int n = 0;
      while (!out_valid && n < 400) begin @(negedge clk); n++; end
      chk("R9 latency", n, 128);
    end

    cur_req = "R8";
    stall = 1;
    for (int i = 0; i < 8; i++) send(rnd16(), rnd16(), rnd16());
    while (!in_ready) @(negedge clk);
    stall = 0;

    cur_req = "R7";
    cfg(2'd0, 32'h0);
    send(-5000, 222, -333);
    cfg(2'd0, 32'h1);
    cur_req = "R5";
    send(7, 1, 2);

    cfg(2'd0, 32'h2);
    chk("R2 restart", coef_done, 0);
    for (int i = 0; i < 10; i++) cfg(2'd1, {16'h0, 16'(-20000 + i * 1000)});
    cfg(2'd0, 32'h1);
    chk("R3 partial", coef_done, 0);
    cur_req = "R4";
    cfg(2'd1, 32'h0000_7fff);
    for (int i = 0; i < 5; i++) send(rnd16(), rnd16() / 2, rnd16() / 2);

    cur_req = "R6";
    cfg(2'd0, 32'h2);
    for (int i = 0; i < 128; i++) cfg(2'd1, 32'h0000_7fff);
    chk("R3 full reload", coef_done, 1);
    cfg(2'd2, 32'h7fff_8000);
    cfg(2'd0, 32'h1);
    for (int i = 0; i < 130; i++) send(32767, 30000, -30000);
    send(32767, -32768, 32767);
    for (int i = 0; i < 130; i++) send(-32768, 0, 0);
    cfg(2'd2, 32'h4000_c000);
    send(-32768, 32767, -32768);
    send(-32768, 5, -5);

    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule